// File: doc/BRIEF.md
# Addressed SPI Memory Access Controller

This block is an SPI slave (mode 0) in front of a 64-location byte array. A transaction opens with a device address byte. That byte carries six identity bits, a poll-select bit and a read/write flag. The identity bits are compared with six strap pins, and the slave takes part in the transaction only when every bit matches. For a memory access, a memory address byte follows, then the data bytes.

Reads stream bytes back from consecutive addresses. Writes collect bytes in an eight-byte page buffer, and the address moves only within the current page. Raising chip select then starts a self-timed commit that lasts a fixed number of clock cycles. A status poll transaction reports a write-in-progress flag, so the host can tell when the commit has finished.

The SPI pins are sampled by the system clock through synchronizers. The serial clock must therefore be several system clocks slower than the system clock. The storage cells are plain registers.

Top module: `addr_spi_mem`

## Requirements
- R1: Bytes are shifted most significant bit first in SPI mode 0. The slave samples SI on a rising SCK edge and changes SO only after a falling SCK edge.
- R2: The device address byte has the identity in bits [7:2], poll-select in bit 1 and the read/write flag in bit 0, where 1 means read. Poll-select takes priority over the read/write flag.
- R3: A device byte whose identity bits differ from `strap_id` abandons the transaction. `spi_miso_oe` stays 0 and no storage location changes.
- R4: The low 6 bits of the memory address byte select one of 64 locations.
- R5: During a write, address bits [5:3] stay fixed and bits [2:0] advance after each data byte. Six bytes written from 15h land at 15h, 16h, 17h, 10h, 11h and 12h.
- R6: A rise of chip select after at least one complete write data byte starts a commit of `WC_CYCLES` clock cycles. Storage is updated when the commit ends.
- R7: A poll transaction returns a status byte after the device byte, and repeats it for every further byte. The byte is 0000000b, where bit 0 (b) is 1 while a commit is in progress.
- R8: A read returns consecutive locations and wraps from 3Fh to 00h. A read during a commit returns the contents from before the commit.
- R9: A write transaction that begins while a commit is in progress is ignored.
- R10: A write that ends before one complete data byte commits nothing and does not start a commit. The bits of an incomplete final byte are discarded.
- R11: After reset, `spi_miso_oe` is 0, no commit is in progress and every location reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_id | input | 6 | Identity levels that the device byte must match |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in (SI) |
| spi_miso | output | 1 | Serial data out (SO) |
| spi_miso_oe | output | 1 | Drive enable for SO; 0 means high impedance |

## Verification
The bench writes every page with its own pattern and reads the whole map back in one burst that runs past 3Fh. A design that got the MSB order or the read increment wrong would return shifted or misplaced bytes, and one without the wrap would stop matching at 00h. A six-byte write from 15h checks the page wrap: a linear increment would spill into 18h, 19h and 1Ah and leave 10h through 12h untouched.

Further cases cover a mismatched identity, a write attempt during a commit, a read during a commit, and writes cut off before the first byte or in the middle of a later byte. Each targets a specific failure: an SO drive that should not happen, a committed write that should have been ignored, a read of data that is not yet committed, or stray bytes written.

// File: rtl/addr_spi_pkg.sv
// Package: shared types and field positions for the addressed SPI memory.
// Assumes bytes of 8 bits and a device byte of {id[5:0], poll, rw}.
package addr_spi_pkg;
    localparam int BYTE_W   = 8;
    localparam int ID_W     = 6;
    localparam int POLL_BIT = 1;
    localparam int RW_BIT   = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_MADDR,
        ST_WDATA,
        ST_RDATA,
        ST_POLL,
        ST_SKIP
    } seq_state_t;
endpackage

// File: rtl/addr_spi_sync.sv
// Module: brings SCK, CS_n and SI into the clk domain and marks edges.
// Assumes SCK half periods last several clk cycles; outputs are single-cycle strobes.
module addr_spi_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_start,
    output logic cs_end,
    output logic cs_act,
    output logic mosi_s
);
    logic [SYNC_STAGES-1:0] sck_q, cs_q, mosi_q;
    logic sck_d, cs_d;

    // Synchronizer chains and the previous-value registers used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= '0;
            cs_q  <= '1;
            mosi_q <= '0;
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_q <= {sck_q[SYNC_STAGES-2:0], sck};
            cs_q  <= {cs_q[SYNC_STAGES-2:0], cs_n};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
            sck_d <= sck_q[SYNC_STAGES-1];
            cs_d  <= cs_q[SYNC_STAGES-1];
        end
    end

    // Edge strobes from the synchronized levels.
    always_comb begin
        sck_rise = sck_q[SYNC_STAGES-1] & ~sck_d;
        sck_fall = ~sck_q[SYNC_STAGES-1] & sck_d;
        cs_start = ~cs_q[SYNC_STAGES-1] & cs_d;
        cs_end   = cs_q[SYNC_STAGES-1] & ~cs_d;
        cs_act   = ~cs_q[SYNC_STAGES-1];
        mosi_s   = mosi_q[SYNC_STAGES-1];
    end
endmodule

// File: rtl/addr_spi_seq.sv
// Module: transaction sequencer. Shifts bytes in and out, decodes the device
// byte, matches the identity, and walks read and write addresses.
// Assumes synchronized strobes from addr_spi_sync; a read uses storage data combinationally.
module addr_spi_seq
    import addr_spi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int PAGE_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sck_rise,
    input  logic                      sck_fall,
    input  logic                      cs_start,
    input  logic                      cs_end,
    input  logic                      cs_act,
    input  logic                      mosi_s,
    input  logic [ID_W-1:0]           strap_id,
    input  logic                      busy,
    input  logic [BYTE_W-1:0]         rd_data,
    output logic [ADDR_W-1:0]         rd_addr,
    output logic                      wr_en,
    output logic [PAGE_W-1:0]         wr_low,
    output logic [BYTE_W-1:0]         wr_data,
    output logic                      buf_clr,
    output logic                      commit,
    output logic [ADDR_W-PAGE_W-1:0]  page,
    output seq_state_t                state_o,
    output logic                      miso,
    output logic                      miso_oe
);
    seq_state_t        state;
    logic [BYTE_W-1:0] rx_sh, tx_sh;
    logic [2:0]        bit_cnt;
    logic [ADDR_W-1:0] cur_addr;
    logic              rd_mode, wrote;
    logic [BYTE_W-1:0] rx_next;
    logic [BYTE_W-1:0] status_byte;

    // Next received byte and the status byte returned by a poll.
    always_comb begin
        rx_next     = {rx_sh[BYTE_W-2:0], mosi_s};
        status_byte = {{(BYTE_W-1){1'b0}}, busy};
    end

    // Main sequencer: framing, byte decode, address walk and the output shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            rx_sh    <= '0;
            tx_sh    <= '0;
            bit_cnt  <= '0;
            cur_addr <= '0;
            rd_mode  <= 1'b0;
            wrote    <= 1'b0;
            wr_en    <= 1'b0;
            wr_low   <= '0;
            wr_data  <= '0;
            buf_clr  <= 1'b0;
            commit   <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            buf_clr <= 1'b0;
            commit  <= 1'b0;
            if (cs_start) begin
                state   <= ST_DEV;
                bit_cnt <= '0;
                wrote   <= 1'b0;
                tx_sh   <= '0;
            end else if (cs_end) begin
                if (state == ST_WDATA && wrote && !busy)
                    commit <= 1'b1;
                state <= ST_IDLE;
            end else if (cs_act && sck_rise && state != ST_IDLE && state != ST_SKIP) begin
                rx_sh   <= rx_next;
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    case (state)
                        ST_DEV: begin
                            if (rx_next[BYTE_W-1:BYTE_W-ID_W] != strap_id)
                                state <= ST_SKIP;
                            else if (rx_next[POLL_BIT])
                                state <= ST_POLL;
                            else if (rx_next[RW_BIT]) begin
                                state   <= ST_MADDR;
                                rd_mode <= 1'b1;
                            end else if (busy)
                                state <= ST_SKIP;
                            else begin
                                state   <= ST_MADDR;
                                rd_mode <= 1'b0;
                            end
                        end
                        ST_MADDR: begin
                            cur_addr <= rx_next[ADDR_W-1:0];
                            if (rd_mode)
                                state <= ST_RDATA;
                            else begin
                                state   <= ST_WDATA;
                                buf_clr <= 1'b1;
                            end
                        end
                        ST_WDATA: begin
                            wr_en   <= 1'b1;
                            wr_low  <= cur_addr[PAGE_W-1:0];
                            wr_data <= rx_next;
                            cur_addr[PAGE_W-1:0] <= cur_addr[PAGE_W-1:0] + 1'b1;
                            wrote   <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end else if (cs_act && sck_fall && (state == ST_RDATA || state == ST_POLL)) begin
                if (bit_cnt == 3'd0) begin
                    if (state == ST_RDATA) begin
                        tx_sh    <= rd_data;
                        cur_addr <= cur_addr + 1'b1;
                    end else
                        tx_sh <= status_byte;
                end else
                    tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // Output view of the sequencer state.
    always_comb begin
        rd_addr = cur_addr;
        page    = cur_addr[ADDR_W-1:PAGE_W];
        state_o = state;
        miso    = tx_sh[BYTE_W-1];
        miso_oe = cs_act && (state == ST_RDATA || state == ST_POLL);
    end
endmodule

// File: rtl/addr_spi_store.sv
// Module: register storage, page buffer and self-timed commit timer.
// Assumes writes to the buffer arrive only while no commit is in progress.
module addr_spi_store
    import addr_spi_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int PAGE_W    = 3,
    parameter int WC_CYCLES = 1000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [PAGE_W-1:0]         wr_low,
    input  logic [BYTE_W-1:0]         wr_data,
    input  logic                      buf_clr,
    input  logic                      commit,
    input  logic [ADDR_W-PAGE_W-1:0]  commit_page,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [BYTE_W-1:0]         rd_data,
    output logic                      busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SLOTS = 1 << PAGE_W;
    localparam int CNT_W = $clog2(WC_CYCLES + 1);

    logic [BYTE_W-1:0]         mem [DEPTH];
    logic [BYTE_W-1:0]         pbuf [SLOTS];
    logic [SLOTS-1:0]          pmask;
    logic [ADDR_W-PAGE_W-1:0]  page_q;
    logic [CNT_W-1:0]          cnt;
    logic                      done;

    // One buffer slot per in-page offset, each with its own valid flag.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Capture a data byte addressed to this slot; clear the flag at a new write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pbuf[s]  <= '0;
                pmask[s] <= 1'b0;
            end else if (buf_clr) begin
                pmask[s] <= 1'b0;
            end else if (wr_en && wr_low == PAGE_W'(s)) begin
                pbuf[s]  <= wr_data;
                pmask[s] <= 1'b1;
            end
        end
    end

    assign done = busy && (cnt == '0);

    // Commit timer: counts the self-timed cycle and latches the target page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            page_q <= '0;
        end else if (commit && !busy) begin
            busy   <= 1'b1;
            cnt    <= CNT_W'(WC_CYCLES - 1);
            page_q <= commit_page;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Storage array: copy the valid buffer slots at the end of a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (done) begin
            for (int k = 0; k < SLOTS; k++)
                if (pmask[k]) mem[{page_q, PAGE_W'(k)}] <= pbuf[k];
        end
    end

    // Combinational read port for the sequencer.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/addr_spi_mem.sv
// Module: top of the addressed SPI memory controller (SPI mode 0 slave).
// Assumes the SPI clock is at least 8x slower than clk.
module addr_spi_mem
    import addr_spi_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int PAGE_W      = 3,
    parameter int WC_CYCLES   = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] strap_id,
    input  logic            spi_sck,
    input  logic            spi_cs_n,
    input  logic            spi_mosi,
    output logic            spi_miso,
    output logic            spi_miso_oe
);
    logic sck_rise, sck_fall, cs_start, cs_end, cs_act, mosi_s;
    logic wr_en, buf_clr, commit, busy;
    logic [PAGE_W-1:0]        wr_low;
    logic [BYTE_W-1:0]        wr_data, rd_data;
    logic [ADDR_W-1:0]        rd_addr;
    logic [ADDR_W-PAGE_W-1:0] page;
    seq_state_t               seq_state;

    addr_spi_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_start(cs_start),
        .cs_end(cs_end), .cs_act(cs_act), .mosi_s(mosi_s)
    );

    addr_spi_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_start(cs_start), .cs_end(cs_end), .cs_act(cs_act), .mosi_s(mosi_s),
        .strap_id(strap_id), .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_low(wr_low), .wr_data(wr_data), .buf_clr(buf_clr),
        .commit(commit), .page(page), .state_o(seq_state),
        .miso(spi_miso), .miso_oe(spi_miso_oe)
    );

    addr_spi_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WC_CYCLES(WC_CYCLES)) i_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_low(wr_low), .wr_data(wr_data),
        .buf_clr(buf_clr), .commit(commit), .commit_page(page), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy)
    );
endmodule

// File: rtl/addr_spi_mem_chk.sv
// Module: assertion checker bound to addr_spi_mem.
// Assumes it observes the internal strobes of the top through the bind below.
module addr_spi_mem_chk
    import addr_spi_pkg::*;
#(
    parameter int PG_W      = 3,
    parameter int WC_CYCLES = 1000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_act,
    input logic            miso_oe,
    input logic            commit,
    input logic            busy,
    input logic            wr_en,
    input logic [PG_W-1:0] page,
    input seq_state_t      state
);
    int busy_run;

    // Length of the current busy phase.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else busy_run <= 0;
    end

    // R3: SO is driven only inside a selected transaction.
    a_r3_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> cs_act);
    // R6: a commit strobe starts the busy phase.
    a_r6_commit_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);
    // R6: the busy phase lasts no longer than WC_CYCLES.
    a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= WC_CYCLES);
    // R9: no commit and no buffer write while a commit is in progress.
    a_r9_no_commit_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy);
    a_r9_no_write_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy);
    // R5: page bits hold while write data streams in.
    a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && $past(state) == ST_WDATA) |-> $stable(page));
endmodule

bind addr_spi_mem addr_spi_mem_chk #(.PG_W(ADDR_W - PAGE_W), .WC_CYCLES(WC_CYCLES)) i_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .miso_oe(spi_miso_oe),
    .commit(commit), .busy(busy), .wr_en(wr_en), .page(page), .state(seq_state)
);

// File: tb/test_addr_spi_mem.sv
// Bench: serial master model for addr_spi_mem, with an arithmetic memory model.
module test_addr_spi_mem;
    localparam int HALF = 8;
    localparam int WC   = 1000;
    localparam logic [5:0] STRAP = 6'h2B;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe;
    int total = 0, bad = 0;
    bit finished = 0;
    bit oe_seen;
    logic [7:0] model [64];

    always #2.5 clk = ~clk;

    addr_spi_mem #(.WC_CYCLES(WC)) i_addr_spi_mem (
        .clk(clk), .rst_n(rst_n), .strap_id(STRAP), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dev(input logic [5:0] id, input bit poll, input bit rd);
        return {id, poll, rd};
    endfunction

    // Shift n bits MSB first; capture SO before each rising edge.
    task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            if (miso_oe) oe_seen = 1;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
        return seed + 8'(k * 29);
    endfunction

    // Write n data bytes from address a (id chosen by caller).
    task automatic wr(input logic [5:0] id, input logic [5:0] a, input int n, input logic [7:0] seed);
        logic [7:0] r;
        cs_lo();
        bits(dev(id, 0, 0), 8, r);
        bits({2'b00, a}, 8, r);
        for (int k = 0; k < n; k++) bits(pat(seed, k), 8, r);
        cs_hi();
    endtask

    // Expected placement: page fixed, low three bits wrap.
    task automatic model_wr(input logic [5:0] a, input int n, input logic [7:0] seed);
        for (int k = 0; k < n; k++)
            model[{a[5:3], 3'(a[2:0] + 3'(k))}] = pat(seed, k);
    endtask

    task automatic rd_check(input logic [5:0] a, input int n, input string tag);
        logic [7:0] r;
        cs_lo();
        bits(dev(STRAP, 0, 1), 8, r);
        bits({2'b00, a}, 8, r);
        for (int k = 0; k < n; k++) begin
            bits(8'h00, 8, r);
            check(r, model[6'(a + 6'(k))], $sformatf("%s addr=%h", tag, 6'(a + 6'(k))));
        end
        cs_hi();
    endtask

    task automatic poll(input logic [7:0] exp, input string tag);
        logic [7:0] r;
        cs_lo();
        bits(dev(STRAP, 1, 1), 8, r);
        bits(8'h00, 8, r);
        check(r, exp, tag);
        bits(8'h00, 8, r);
        check(r, exp, {tag, " repeat"});
        cs_hi();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({7'b0, miso_oe}, 8'h00, "R11 oe after reset");
        poll(8'h00, "R11 R7 R2 idle status");
        rd_check(6'h00, 4, "R11 reset contents");

        // Every page, full width, distinct pattern per page.
        for (int p = 0; p < 8; p++) begin
            wr(STRAP, 6'(p * 8), 8, 8'(p * 16 + 3));
            poll(8'h01, $sformatf("R6 R7 wip during commit page=%0d", p));
            repeat (WC) @(negedge clk);
            poll(8'h00, $sformatf("R6 wip cleared page=%0d", p));
            model_wr(6'(p * 8), 8, 8'(p * 16 + 3));
        end
        rd_check(6'h00, 66, "R8 R4 R1 full burst");
        rd_check(6'h3E, 4, "R8 wrap 3F to 00");

        // Page wrap.
        wr(STRAP, 6'h15, 6, 8'hA0);
        repeat (WC + 20) @(negedge clk);
        model_wr(6'h15, 6, 8'hA0);
        rd_check(6'h10, 8, "R5 page wrap");

        // Identity mismatch: write abandoned, read never drives SO.
        wr(STRAP ^ 6'h01, 6'h08, 3, 8'h11);
        poll(8'h00, "R3 no commit on mismatch");
        oe_seen = 0;
        cs_lo();
        bits(dev(STRAP ^ 6'h20, 0, 1), 8, r);
        bits(8'h08, 8, r);
        bits(8'h00, 8, r);
        cs_hi();
        check({7'b0, oe_seen}, 8'h00, "R3 R2 oe on mismatched read");
        rd_check(6'h08, 3, "R3 memory unchanged");

        // Busy phase: read sees old data, second write ignored.
        wr(STRAP, 6'h20, 1, 8'h55);
        rd_check(6'h20, 1, "R8 read during commit old data");
        wr(STRAP, 6'h30, 1, 8'h77);
        repeat (WC) @(negedge clk);
        model_wr(6'h20, 1, 8'h55);
        rd_check(6'h20, 1, "R6 committed byte");
        rd_check(6'h30, 1, "R9 write during commit ignored");
        poll(8'h00, "R9 no second commit");

        // No complete data byte.
        cs_lo();
        bits(dev(STRAP, 0, 0), 8, r);
        bits(8'h38, 8, r);
        bits(8'hFF, 5, r);
        cs_hi();
        poll(8'h00, "R10 no commit without full byte");
        rd_check(6'h38, 1, "R10 location unchanged");

        // Partial tail discarded.
        cs_lo();
        bits(dev(STRAP, 0, 0), 8, r);
        bits(8'h39, 8, r);
        bits(pat(8'hC4, 0), 8, r);
        bits(pat(8'hC4, 1), 8, r);
        bits(8'hFF, 3, r);
        cs_hi();
        poll(8'h01, "R10 commit after full bytes");
        repeat (WC) @(negedge clk);
        model_wr(6'h39, 2, 8'hC4);
        rd_check(6'h39, 3, "R10 partial tail discarded");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule